// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block drives a parallel RGB LCD panel. It counts pixel clocks with a single counter that runs across the whole frame. From that count it produces horizontal and vertical sync, a data-enable that covers the display window, and a pixel output. Inside the display window, an optional narrower active window can be switched on. Pixels that fall in the display window but outside an enabled active window are painted in a border colour.

Pixels arrive from an upstream valid/ready stream. The block asserts ready only on active-window pixels. If the source has nothing to give on such a pixel, the block substitutes an underflow colour. With recovery switched on, every remaining active pixel of that frame shows the underflow colour, and real data resumes at the next frame start.

All settings live in a word-addressed register bank on a simple write/read bus. Vertical positions are absolute pixel-clock counts from the start of the frame, not line numbers. Timing values are copied into a shadow set at each frame start, so every frame runs on one consistent set of values.

Top module: `lcd_timing_gen`

## Requirements
- R1: The enable flag is bit 0 of byte offset 0x00. While it is 0, the counters hold at zero, pixReady is 0 and pixOut is 0. hsyncOut, vsyncOut and deOut rest at their inactive levels. In the first cycle after enable is written to 1, the frame count is 0.
- R2: Offset 0x04 holds the line period in bits [31:16] and the hsync width in bits [15:0]. The position within a line is the frame count modulo the line period. The internal hsync is active while that position is below the hsync width.
- R3: Offset 0x08 holds the frame period and offset 0x0C the vsync width, both in pixel clocks. Offset 0x30 holds the hsync skew. The frame count runs from 0 to the frame period minus 1 and then wraps. The internal vsync is active while skew <= count < skew + vsync width.
- R4: The display window is the set of pixels where the line position lies within [start, end] of offset 0x10, and the frame count lies within [0x14, 0x18]. The start is in bits [15:0] of 0x10, the end in bits [31:16], and both bounds are inclusive. The internal data-enable is active exactly on that window. All outputs except pixReady are registered and describe the count of the previous cycle.
- R5: Offset 0x1C holds the horizontal active bounds: start in bits [15:0], end in bits [30:16], and an enable in bit 31. Offset 0x20 bits [30:0] hold the vertical active start, with its enable in bit 31. Offset 0x24 holds the vertical active end. A dimension whose enable is clear follows the display window in that dimension. pixReady is 1 exactly on active pixels, combinationally, in the same cycle as the count.
- R6: A pixel inside the display window but outside the active window shows the border colour from offset 0x28 bits [23:0]. A pixel outside the display window shows 0.
- R7: Offset 0x2C bits [23:0] hold the underflow colour. If pixValid is 0 on an active pixel and recovery is off, only that pixel shows the underflow colour.
- R8: With recovery on (0x2C bit 31), an active pixel with pixValid at 0 switches to the underflow colour for every remaining active pixel of the frame, whatever pixValid does. Real data returns from the next frame start.
- R9: Offset 0x34 bit 0 is a sticky status bit. It is set whenever a pixel is substituted. Writing 1 to it clears it; writing 0 leaves it unchanged.
- R10: Offset 0x38 holds the output polarities: bit 0 for hsync, bit 1 for vsync, bit 2 for data enable. A 1 makes that output active-low.
- R11: Timing, colour, recovery and polarity writes made while running take effect at the next frame start. While disabled, they take effect at once.
- R12: Each configuration register reads back the field values last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 6 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| pixValid | input | 1 | Source has a pixel |
| pixData | input | PIX_W | Source pixel |
| pixReady | output | 1 | Pixel consumed this cycle |
| hsyncOut | output | 1 | Horizontal sync after polarity |
| vsyncOut | output | 1 | Vertical sync after polarity |
| deOut | output | 1 | Data enable after polarity |
| pixOut | output | PIX_W | Panel pixel data |

## Verification
A wrong frame or line count shows up as an hsync, vsync or data-enable edge in the wrong cycle. It is visible within one line for horizontal faults and within one frame for vertical faults. A shadow set loaded at the wrong moment changes the window shape part-way through a frame instead of at the wrap. A recovery flag that does not clear, or does not stick, shows as pixOut disagreeing with the source on the next active pixel. The sticky status and every setting are also read back through the register bus right after the stimulus that should have changed them.

// File: rtl/lcdtg_pkg.sv
package lcdtg_pkg;
  localparam int REG_W  = 32;
  localparam int POS_W  = 16;
  localparam int CNT_W  = 32;
  localparam int ADDR_W = 6;

  localparam logic [CNT_W-1:0] CNT_ONE = 1;
  localparam logic [POS_W-1:0] POS_ONE = 1;

  localparam logic [ADDR_W-1:0] OFS_ENABLE  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_HTIME   = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_FRAME   = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_VSYNC   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_HDISP   = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_VDSTART = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_VDEND   = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_HACT    = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_VASTART = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_VAEND   = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_BORDER  = 6'h28;
  localparam logic [ADDR_W-1:0] OFS_UFLOW   = 6'h2C;
  localparam logic [ADDR_W-1:0] OFS_SKEW    = 6'h30;
  localparam logic [ADDR_W-1:0] OFS_STATUS  = 6'h34;
  localparam logic [ADDR_W-1:0] OFS_POL     = 6'h38;

  // Timing set, held live and shadowed per frame
  typedef struct packed {
    logic [POS_W-1:0] linePeriod;
    logic [POS_W-1:0] hsyncWidth;
    logic [POS_W-1:0] hDispStart;
    logic [POS_W-1:0] hDispEnd;
    logic             actHEn;
    logic [POS_W-2:0] actHEnd;
    logic [POS_W-1:0] actHStart;
    logic [CNT_W-1:0] framePeriod;
    logic [CNT_W-1:0] vsyncWidth;
    logic [CNT_W-1:0] vDispStart;
    logic [CNT_W-1:0] vDispEnd;
    logic             actVEn;
    logic [CNT_W-2:0] actVStart;
    logic [CNT_W-1:0] actVEnd;
    logic [CNT_W-1:0] hsyncSkew;
    logic [2:0]       polarity;
    logic             recovEn;
  } tgCfg_t;

  // Strobes from control to datapath, one set per pixel clock
  typedef struct packed {
    logic run;
    logic frameStart;
    logic hsyncOn;
    logic vsyncOn;
    logic inDisp;
    logic inActive;
  } tgStrobe_t;
endpackage

// File: rtl/lcdtg_ctrl.sv
module lcdtg_ctrl
  import lcdtg_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              uflowEvent,
  output tgStrobe_t         strb,
  output logic [PIX_W-1:0]  borderColor,
  output logic [PIX_W-1:0]  underColor,
  output logic              recovEn,
  output logic [2:0]        polarity
);
  tgCfg_t liveCfg, shCfg;
  logic enReg, statusBit, clrStatus;
  logic [PIX_W-1:0] liveBorder, liveUnder, shBorder, shUnder;
  logic [CNT_W-1:0] frameCnt;
  logic [POS_W-1:0] hPos;
  logic frameLast, lineLast;
  logic hDisp, vDisp, hAct, vAct;
  logic [CNT_W:0] vsEnd;

  assign clrStatus = regWrEn && (regAddr == OFS_STATUS) && regWrData[0];

  // Live register bank
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      liveCfg    <= '0;
      enReg      <= 1'b0;
      liveBorder <= '0;
      liveUnder  <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        OFS_ENABLE:  enReg <= regWrData[0];
        OFS_HTIME: begin
          liveCfg.linePeriod <= regWrData[31:16];
          liveCfg.hsyncWidth <= regWrData[15:0];
        end
        OFS_FRAME:   liveCfg.framePeriod <= regWrData;
        OFS_VSYNC:   liveCfg.vsyncWidth  <= regWrData;
        OFS_HDISP: begin
          liveCfg.hDispEnd   <= regWrData[31:16];
          liveCfg.hDispStart <= regWrData[15:0];
        end
        OFS_VDSTART: liveCfg.vDispStart <= regWrData;
        OFS_VDEND:   liveCfg.vDispEnd   <= regWrData;
        OFS_HACT: begin
          liveCfg.actHEn    <= regWrData[31];
          liveCfg.actHEnd   <= regWrData[30:16];
          liveCfg.actHStart <= regWrData[15:0];
        end
        OFS_VASTART: begin
          liveCfg.actVEn    <= regWrData[31];
          liveCfg.actVStart <= regWrData[30:0];
        end
        OFS_VAEND:   liveCfg.actVEnd <= regWrData;
        OFS_BORDER:  liveBorder <= regWrData[PIX_W-1:0];
        OFS_UFLOW: begin
          liveCfg.recovEn <= regWrData[31];
          liveUnder       <= regWrData[PIX_W-1:0];
        end
        OFS_SKEW:    liveCfg.hsyncSkew <= regWrData;
        OFS_POL:     liveCfg.polarity  <= regWrData[2:0];
        default: ;
      endcase
    end
  end

  // Read mux
  always_comb begin
    regRdData = '0;
    case (regAddr)
      OFS_ENABLE:  regRdData[0] = enReg;
      OFS_HTIME:   regRdData = {liveCfg.linePeriod, liveCfg.hsyncWidth};
      OFS_FRAME:   regRdData = liveCfg.framePeriod;
      OFS_VSYNC:   regRdData = liveCfg.vsyncWidth;
      OFS_HDISP:   regRdData = {liveCfg.hDispEnd, liveCfg.hDispStart};
      OFS_VDSTART: regRdData = liveCfg.vDispStart;
      OFS_VDEND:   regRdData = liveCfg.vDispEnd;
      OFS_HACT:    regRdData = {liveCfg.actHEn, liveCfg.actHEnd, liveCfg.actHStart};
      OFS_VASTART: regRdData = {liveCfg.actVEn, liveCfg.actVStart};
      OFS_VAEND:   regRdData = liveCfg.actVEnd;
      OFS_BORDER:  regRdData[PIX_W-1:0] = liveBorder;
      OFS_UFLOW: begin
        regRdData[PIX_W-1:0] = liveUnder;
        regRdData[31]        = liveCfg.recovEn;
      end
      OFS_SKEW:    regRdData = liveCfg.hsyncSkew;
      OFS_STATUS:  regRdData[0] = statusBit;
      OFS_POL:     regRdData[2:0] = liveCfg.polarity;
      default:     regRdData = '0;
    endcase
  end

  // Frame-boundary shadow copy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shCfg    <= '0;
      shBorder <= '0;
      shUnder  <= '0;
    end else if (!enReg || frameLast) begin
      shCfg    <= liveCfg;
      shBorder <= liveBorder;
      shUnder  <= liveUnder;
    end
  end

  // Frame and line position counters
  assign frameLast = enReg && (frameCnt == shCfg.framePeriod - CNT_ONE);
  assign lineLast  = (hPos == shCfg.linePeriod - POS_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frameCnt <= '0;
      hPos     <= '0;
    end else if (!enReg || frameLast) begin
      frameCnt <= '0;
      hPos     <= '0;
    end else begin
      frameCnt <= frameCnt + CNT_ONE;
      hPos     <= lineLast ? '0 : hPos + POS_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) statusBit <= 1'b0;
    else        statusBit <= (statusBit && !clrStatus) || uflowEvent;
  end

  // Window decode
  always_comb begin
    hDisp = (hPos >= shCfg.hDispStart) && (hPos <= shCfg.hDispEnd);
    vDisp = (frameCnt >= shCfg.vDispStart) && (frameCnt <= shCfg.vDispEnd);
    hAct  = !shCfg.actHEn ||
            ((hPos >= shCfg.actHStart) && (hPos <= {1'b0, shCfg.actHEnd}));
    vAct  = !shCfg.actVEn ||
            ((frameCnt >= {1'b0, shCfg.actVStart}) && (frameCnt <= shCfg.actVEnd));
    vsEnd = {1'b0, shCfg.hsyncSkew} + {1'b0, shCfg.vsyncWidth};
    strb.run        = enReg;
    strb.frameStart = enReg && (frameCnt == '0);
    strb.hsyncOn    = hPos < shCfg.hsyncWidth;
    strb.vsyncOn    = (frameCnt >= shCfg.hsyncSkew) && ({1'b0, frameCnt} < vsEnd);
    strb.inDisp     = hDisp && vDisp;
    strb.inActive   = hDisp && vDisp && hAct && vAct;
  end

  assign borderColor = shBorder;
  assign underColor  = shUnder;
  assign recovEn     = shCfg.recovEn;
  assign polarity    = shCfg.polarity;

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enReg) |-> (frameCnt == '0 && hPos == '0)); // R1
  AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (enReg && shCfg.framePeriod != '0) |-> (frameCnt < shCfg.framePeriod)); // R3
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enReg && !frameLast) |=> $stable(shCfg)); // R11
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (statusBit && !clrStatus) |=> statusBit); // R9
endmodule

// File: rtl/lcdtg_datapath.sv
module lcdtg_datapath
  import lcdtg_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tgStrobe_t        strb,
  input  logic [2:0]       polarity,
  input  logic             recovEn,
  input  logic [PIX_W-1:0] borderColor,
  input  logic [PIX_W-1:0] underColor,
  input  logic             pixValid,
  input  logic [PIX_W-1:0] pixData,
  output logic             pixReady,
  output logic             uflowEvent,
  output logic             hsyncOut,
  output logic             vsyncOut,
  output logic             deOut,
  output logic [PIX_W-1:0] pixOut
);
  logic hsRaw, vsRaw, deRaw;
  logic [2:0] polQ;
  logic [PIX_W-1:0] pixReg;
  logic uflowMode, effMode, starve, lockSet;

  assign effMode    = uflowMode && !strb.frameStart;
  assign starve     = strb.inActive && !pixValid;
  assign lockSet    = starve && recovEn;
  assign pixReady   = strb.run && strb.inActive;
  assign uflowEvent = pixReady && (!pixValid || effMode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsRaw     <= 1'b0;
      vsRaw     <= 1'b0;
      deRaw     <= 1'b0;
      polQ      <= '0;
      pixReg    <= '0;
      uflowMode <= 1'b0;
    end else begin
      polQ <= polarity;
      if (!strb.run) begin
        hsRaw     <= 1'b0;
        vsRaw     <= 1'b0;
        deRaw     <= 1'b0;
        pixReg    <= '0;
        uflowMode <= 1'b0;
      end else begin
        hsRaw <= strb.hsyncOn;
        vsRaw <= strb.vsyncOn;
        deRaw <= strb.inDisp;
        if (!strb.inDisp)        pixReg <= '0;
        else if (!strb.inActive) pixReg <= borderColor;
        else if (uflowEvent)     pixReg <= underColor;
        else                     pixReg <= pixData;
        uflowMode <= strb.frameStart ? lockSet : (uflowMode || lockSet);
      end
    end
  end

  assign hsyncOut = hsRaw ^ polQ[0];
  assign vsyncOut = vsRaw ^ polQ[1];
  assign deOut    = deRaw ^ polQ[2];
  assign pixOut   = pixReg;

  AST_IDLE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.run |=> (!deRaw && pixOut == '0)); // R1
  AST_UFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.run && uflowMode && !strb.frameStart) |=> uflowMode); // R8
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.run |-> !pixReady); // R5
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcdtg_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              pixValid,
  input  logic [PIX_W-1:0]  pixData,
  output logic              pixReady,
  output logic              hsyncOut,
  output logic              vsyncOut,
  output logic              deOut,
  output logic [PIX_W-1:0]  pixOut
);
  tgStrobe_t strb;
  logic [PIX_W-1:0] borderColor, underColor;
  logic recovEn, uflowEvent;
  logic [2:0] polarity;

  lcdtg_ctrl #(.PIX_W(PIX_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .uflowEvent(uflowEvent),
    .strb(strb), .borderColor(borderColor), .underColor(underColor),
    .recovEn(recovEn), .polarity(polarity)
  );

  lcdtg_datapath #(.PIX_W(PIX_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .polarity(polarity),
    .recovEn(recovEn), .borderColor(borderColor), .underColor(underColor),
    .pixValid(pixValid), .pixData(pixData), .pixReady(pixReady),
    .uflowEvent(uflowEvent), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut),
    .deOut(deOut), .pixOut(pixOut)
  );
endmodule

// File: tb/lcd_timing_gen_tb_top.sv
`timescale 1ns/1ps
module lcd_timing_gen_tb_top;
  localparam int PIX_W = 24;
  localparam int FRAME = 72;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic regWrEn = 1'b0;
  logic [5:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic pixValid = 1'b0;
  logic [PIX_W-1:0] pixData = '0;
  logic pixReady, hsyncOut, vsyncOut, deOut;
  logic [PIX_W-1:0] pixOut;

  int checkCnt = 0;
  int passCnt = 0;
  bit finished = 1'b0;
  logic [31:0] starveAt = 32'hFFFF_FFFF;
  logic [23:0] seqVal = '0;

  // Reference model state, built from the requirements
  logic [31:0] mLive [16];
  logic [31:0] mSh [16];
  logic [31:0] mCnt;
  logic mMode, mHs, mVs, mDe;
  logic [PIX_W-1:0] mPix;
  logic mRun, mAct, mDisp, mSub, mEff, mRec, mWrap, mSet;
  logic [2:0] mPol;

  lcd_timing_gen #(.PIX_W(PIX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pixValid(pixValid),
    .pixData(pixData), .pixReady(pixReady), .hsyncOut(hsyncOut),
    .vsyncOut(vsyncOut), .deOut(deOut), .pixOut(pixOut)
  );

  function automatic logic [31:0] fnHpos(input logic [31:0] c);
    if (mSh[1][31:16] == 16'd0) return c;
    return c % {16'b0, mSh[1][31:16]};
  endfunction

  function automatic logic fnDisp(input logic [31:0] c);
    logic [31:0] h;
    h = fnHpos(c);
    return (h >= {16'b0, mSh[4][15:0]}) && (h <= {16'b0, mSh[4][31:16]}) &&
           (c >= mSh[5]) && (c <= mSh[6]);
  endfunction

  function automatic logic fnAct(input logic [31:0] c);
    logic [31:0] h;
    logic hOk, vOk;
    h = fnHpos(c);
    hOk = !mSh[7][31] || ((h >= {16'b0, mSh[7][15:0]}) && (h <= {17'b0, mSh[7][30:16]}));
    vOk = !mSh[8][31] || ((c >= {1'b0, mSh[8][30:0]}) && (c <= mSh[9]));
    return fnDisp(c) && hOk && vOk;
  endfunction

  function automatic logic fnHs(input logic [31:0] c);
    return fnHpos(c) < {16'b0, mSh[1][15:0]};
  endfunction

  function automatic logic fnVs(input logic [31:0] c);
    return (c >= mSh[12]) && ({1'b0, c} < ({1'b0, mSh[12]} + {1'b0, mSh[3]}));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin
        mLive[i] = '0;
        mSh[i] = '0;
      end
      mCnt = '0; mMode = 1'b0; mHs = 1'b0; mVs = 1'b0; mDe = 1'b0; mPix = '0;
    end else begin
      mRun  = mLive[0][0];
      mDisp = mRun && fnDisp(mCnt);
      mAct  = mRun && fnAct(mCnt);
      mRec  = mSh[11][31];
      mPol  = mSh[14][2:0];
      mEff  = mMode && (mCnt != 0);
      mSub  = mAct && (!pixValid || mEff);
      mSet  = mAct && !pixValid && mRec;
      mHs   = (mRun && fnHs(mCnt)) ^ mPol[0];
      mVs   = (mRun && fnVs(mCnt)) ^ mPol[1];
      mDe   = mDisp ^ mPol[2];
      if (!mDisp)     mPix = '0;
      else if (!mAct) mPix = mSh[10][PIX_W-1:0];
      else if (mSub)  mPix = mSh[11][PIX_W-1:0];
      else            mPix = pixData;
      if (!mRun)          mMode = 1'b0;
      else if (mCnt == 0) mMode = mSet;
      else                mMode = mMode || mSet;
      mWrap = mRun && (mCnt == mSh[2] - 32'd1);
      mCnt  = (!mRun || mWrap) ? 32'd0 : mCnt + 32'd1;
      if (!mRun || mWrap)
        for (int i = 0; i < 16; i++) mSh[i] = mLive[i];
      if (regWrEn) mLive[regAddr[5:2]] = regWrData;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act === exp) passCnt++;
    else $display("FAIL %s: actual %h expected %h", tag, act, exp);
  endtask

  // One pixel clock: compare all outputs, then drive the next inputs
  task automatic tick(input string tag);
    @(negedge clk);
    check(tag, {4'b0, pixReady, hsyncOut, vsyncOut, deOut, pixOut},
          {4'b0, mLive[0][0] && fnAct(mCnt), mHs, mVs, mDe, mPix});
    regWrEn  = 1'b0;
    seqVal   = seqVal + 24'd1;
    pixData  = 24'hC30000 ^ seqVal;
    pixValid = (mCnt != starveAt);
  endtask

  task automatic writeReg(input logic [5:0] a, input logic [31:0] d, input string tag);
    regWrEn = 1'b1;
    regAddr = a;
    regWrData = d;
    tick(tag);
  endtask

  task automatic readCheck(input logic [5:0] a, input logic [31:0] exp, input string tag);
    regAddr = a;
    #1;
    check(tag, regRdData, exp);
  endtask

  task automatic testReset();
    repeat (3) tick("R1 reset idle");
    readCheck(6'h00, 32'h0, "R1 enable reset");
    readCheck(6'h34, 32'h0, "R9 status reset");
  endtask

  task automatic testBasic();
    writeReg(6'h04, {16'd12, 16'd2}, "R2");
    writeReg(6'h08, 32'd72, "R3");
    writeReg(6'h0C, 32'd12, "R3");
    writeReg(6'h10, {16'd9, 16'd4}, "R4");
    writeReg(6'h14, 32'd24, "R4");
    writeReg(6'h18, 32'd59, "R4");
    writeReg(6'h28, 32'h0000AA55, "R6");
    writeReg(6'h2C, 32'h000000FF, "R7");
    readCheck(6'h04, {16'd12, 16'd2}, "R12 line timing");
    readCheck(6'h28, 32'h0000AA55, "R12 border");
    writeReg(6'h00, 32'd1, "R1 enable");
    repeat (2 * FRAME) tick("R2 R3 R4 R5 frame");
  endtask

  task automatic testActive();
    repeat (20) tick("R4");
    writeReg(6'h1C, {1'b1, 15'd7, 16'd5}, "R11");
    writeReg(6'h20, {1'b1, 31'd36}, "R11");
    writeReg(6'h24, 32'd47, "R11");
    readCheck(6'h1C, {1'b1, 15'd7, 16'd5}, "R12 active h");
    repeat (FRAME) tick("R11 shadow");
    repeat (2 * FRAME) tick("R5 R6 sub-window");
  endtask

  task automatic testUnderflow();
    starveAt = 32'd41;
    repeat (FRAME) tick("R7 single substitution");
    starveAt = 32'hFFFF_FFFF;
    readCheck(6'h34, 32'd1, "R9 sticky set");
    writeReg(6'h34, 32'd0, "R9");
    readCheck(6'h34, 32'd1, "R9 zero write kept");
    writeReg(6'h34, 32'd1, "R9");
    readCheck(6'h34, 32'd0, "R9 cleared");
  endtask

  task automatic testRecovery();
    writeReg(6'h2C, 32'h800000FF, "R8");
    readCheck(6'h2C, 32'h800000FF, "R12 underflow reg");
    repeat (FRAME) tick("R8");
    starveAt = 32'd41;
    repeat (FRAME) tick("R8 recovery locked");
    starveAt = 32'hFFFF_FFFF;
    repeat (FRAME) tick("R8 resume");
  endtask

  task automatic testPolSkew();
    writeReg(6'h38, 32'd7, "R10");
    writeReg(6'h30, 32'd3, "R3");
    writeReg(6'h14, 32'd27, "R4");
    writeReg(6'h18, 32'd62, "R4");
    readCheck(6'h38, 32'd7, "R12 polarity");
    repeat (2 * FRAME) tick("R10 R3 polarity skew");
  endtask

  task automatic testRestart();
    repeat (30) tick("R1");
    writeReg(6'h00, 32'd0, "R1 disable");
    repeat (6) tick("R1 idle");
    readCheck(6'h00, 32'd0, "R1 enable readback");
    writeReg(6'h00, 32'd1, "R1 restart");
    repeat (FRAME + 5) tick("R1 restart frame");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checkCnt++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", passCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testBasic();
    testActive();
    testUnderflow();
    testRecovery();
    testPolSkew();
    testRestart();
    finished = 1'b1;
    $display("%0d/%0d checks passed", passCnt, checkCnt);
    $finish;
  end
endmodule